// File: doc/BRIEF.md
# Segment Descriptor Fault Classifier

This block decides which protection exception, if any, follows from loading or using a segment descriptor. A request presents the register or object being loaded (a code, data or stack segment register, the local descriptor table register, or a gate), the context of the load, the descriptor's present bit, the selector, and a flag from the separate stack-limit comparator. One clock later the block gives a fault pulse, an exception vector, a 16-bit error code and a flag that says where execution restarts.

The vector does not depend on the present bit alone. The same missing descriptor gives the segment-not-present exception for a data segment, the stack exception for the stack segment, and the invalid-TSS exception for a local descriptor table loaded by a task switch. The dispatch logic takes the vector and error code and pushes them.

Top module: `seg_fault_classifier`

## Requirements
- R1: A synchronous active-high reset sets fault_valid, vector, err_code and restart_new_task to zero.
- R2: Target codes are CS=0, DS=1, ES=2, SS=3, LDTR=4, GATE=5. Codes 6 and 7 never give a not-present fault. A not-present descriptor for target 0, 1 or 2 gives vector 11, and err_code is the selector.
- R3: A not-present descriptor for target 3 (SS) gives vector 12, and err_code is the selector. This holds in every context.
- R4: Context codes are ORDINARY=0, LLDT=1, TASK_SWITCH=2, CALL=3, RETURN=4. A not-present descriptor for target 4 gives vector 10 when the context is 2, and vector 11 in any other context. In both cases err_code is the selector.
- R5: A not-present descriptor for target 5 (gate) gives vector 11, and err_code is the selector.
- R6: When the descriptor is present and ss_limit_err is 1, the block gives vector 12 with err_code 0, for any target.
- R7: When the not-present condition for targets 0 to 5 and ss_limit_err occur in the same request, the not-present result wins.
- R8: restart_new_task is 1 on a fault only when target is 0, 1 or 2, the descriptor is not present and the context is 2. On every other fault it is 0.
- R9: All outputs are updated at the first clock edge after req is sampled high. fault_valid is 0 after any edge where req was low.
- R10: A request that raises no fault (present and no limit error, or target 6/7 with no limit error) drives fault_valid to 0 and leaves vector, err_code and restart_new_task unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe |
| target | input | 3 | Register or object being loaded |
| ctx | input | 3 | Context of the load |
| present | input | 1 | Present bit of the fetched descriptor |
| selector | input | 16 | Selector of the descriptor |
| ss_limit_err | input | 1 | Stack segment limit violation |
| fault_valid | output | 1 | One-cycle fault pulse |
| vector | output | 8 | Exception vector |
| err_code | output | 16 | Error code to push |
| restart_new_task | output | 1 | Restart at first instruction of the new task |

## Verification
The bench targets the loads where the vector depends on context. A local descriptor table register loaded by a task switch must give vector 10, while the same load by LLDT gives 11. A stack load in each context must give 12 and never 11. A design that checks only the present bit would report 11 for all of these. The bench also sends a request where the descriptor is missing and the stack limit fails at once: a design with the priority reversed would push a zero error code. It checks that the restart flag is set only for data or code segment loads during a task switch; a wrong flag would re-run the old task's instruction or skip it. Finally it checks that a benign request leaves the previous vector and error code in place.

// File: rtl/seg_fault_classifier.sv
module seg_fault_classifier #(
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [2:0]       target,
  input  logic [2:0]       ctx,
  input  logic             present,
  input  logic [SEL_W-1:0] selector,
  input  logic             ss_limit_err,
  output logic             fault_valid,
  output logic [VEC_W-1:0] vector,
  output logic [SEL_W-1:0] err_code,
  output logic             restart_new_task
);
  localparam logic [2:0] T_CS = 3'd0, T_DS = 3'd1, T_ES = 3'd2, T_SS = 3'd3,
                         T_LDT = 3'd4, T_GATE = 3'd5;
  localparam logic [2:0] C_TASK = 3'd2;
  localparam logic [VEC_W-1:0] V_TSS = VEC_W'(10), V_NP = VEC_W'(11),
                               V_STK = VEC_W'(12);

  logic             np_hit, fire, n_rs;
  logic [VEC_W-1:0] n_vec;
  logic [SEL_W-1:0] n_ec;

  assign np_hit = !present && (target <= T_GATE);
  assign fire   = req && (np_hit || ss_limit_err);

  always_comb begin
    n_vec = V_NP;
    n_ec  = selector;
    n_rs  = 1'b0;
    if (np_hit) begin
      unique case (target)
        T_CS, T_DS, T_ES: n_rs = (ctx == C_TASK);
        T_SS:             n_vec = V_STK;
        T_LDT:            n_vec = (ctx == C_TASK) ? V_TSS : V_NP;
        default:          n_vec = V_NP;
      endcase
    end else begin
      n_vec = V_STK;
      n_ec  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_valid      <= 1'b0;
      vector           <= '0;
      err_code         <= '0;
      restart_new_task <= 1'b0;
    end else begin
      fault_valid <= fire;
      if (fire) begin
        vector           <= n_vec;
        err_code         <= n_ec;
        restart_new_task <= n_rs;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !fault_valid && vector == '0 && err_code == '0); // R1
  AST_CDE_NP: assert property (@(posedge clk) disable iff (rst)
    req && !present && target <= T_ES |=> fault_valid && vector == V_NP && err_code == $past(selector)); // R2
  AST_SS_NP: assert property (@(posedge clk) disable iff (rst)
    req && !present && target == T_SS |=> fault_valid && vector == V_STK && err_code == $past(selector)); // R3
  AST_LDT_TASK: assert property (@(posedge clk) disable iff (rst)
    req && !present && target == T_LDT && ctx == C_TASK |=> vector == V_TSS); // R4
  AST_GATE_NP: assert property (@(posedge clk) disable iff (rst)
    req && !present && target == T_GATE |=> vector == V_NP); // R5
  AST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    req && present && ss_limit_err |=> fault_valid && vector == V_STK && err_code == '0); // R6
  AST_RESTART_ONLY_NP: assert property (@(posedge clk) disable iff (rst)
    fault_valid && restart_new_task |-> vector == V_NP); // R8
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    !req |=> !fault_valid); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    req && present && !ss_limit_err |=> !fault_valid && $stable(vector) && $stable(err_code)); // R10
endmodule

// File: tb/sim_seg_fault_classifier.sv
module sim_seg_fault_classifier;
  logic clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic [2:0] target = '0, ctx = '0;
  logic present = 1'b1, ss_limit_err = 1'b0;
  logic [15:0] selector = '0;
  logic fault_valid, restart_new_task;
  logic [7:0] vector;
  logic [15:0] err_code;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  seg_fault_classifier u0 (.clk, .rst, .req, .target, .ctx, .present, .selector,
    .ss_limit_err, .fault_valid, .vector, .err_code, .restart_new_task);

  typedef struct packed {
    logic [2:0]  tg;
    logic [2:0]  cx;
    logic        pr;
    logic [15:0] sel;
    logic        lim;
    logic [7:0]  evec;
    logic [15:0] eec;
    logic        ers;
    logic [3:0]  rq;
  } vec_t;

  localparam int N = 16;
  localparam vec_t TBL [N] = '{
    '{3'd0, 3'd0, 1'b0, 16'h1230, 1'b0, 8'd11, 16'h1230, 1'b0, 4'd2},  // R2 CS
    '{3'd1, 3'd0, 1'b0, 16'h2238, 1'b0, 8'd11, 16'h2238, 1'b0, 4'd2},  // R2 DS
    '{3'd2, 3'd3, 1'b0, 16'h0044, 1'b0, 8'd11, 16'h0044, 1'b0, 4'd2},  // R2 ES
    '{3'd3, 3'd0, 1'b0, 16'h0050, 1'b0, 8'd12, 16'h0050, 1'b0, 4'd3},  // R3 MOV SS
    '{3'd3, 3'd2, 1'b0, 16'h0058, 1'b0, 8'd12, 16'h0058, 1'b0, 4'd3},  // R3 task switch
    '{3'd3, 3'd3, 1'b0, 16'h0063, 1'b0, 8'd12, 16'h0063, 1'b0, 4'd3},  // R3 call
    '{3'd3, 3'd4, 1'b0, 16'h006B, 1'b0, 8'd12, 16'h006B, 1'b0, 4'd3},  // R3 return
    '{3'd4, 3'd1, 1'b0, 16'h0070, 1'b0, 8'd11, 16'h0070, 1'b0, 4'd4},  // R4 LLDT
    '{3'd4, 3'd2, 1'b0, 16'h0078, 1'b0, 8'd10, 16'h0078, 1'b0, 4'd4},  // R4 task switch
    '{3'd5, 3'd0, 1'b0, 16'h0083, 1'b0, 8'd11, 16'h0083, 1'b0, 4'd5},  // R5 gate
    '{3'd3, 3'd0, 1'b1, 16'h0090, 1'b1, 8'd12, 16'h0000, 1'b0, 4'd6},  // R6 SS limit
    '{3'd1, 3'd3, 1'b1, 16'h0098, 1'b1, 8'd12, 16'h0000, 1'b0, 4'd6},  // R6 interlevel stack
    '{3'd3, 3'd3, 1'b0, 16'h00A0, 1'b1, 8'd12, 16'h00A0, 1'b0, 4'd7},  // R7 SS np + limit
    '{3'd0, 3'd0, 1'b0, 16'h00A8, 1'b1, 8'd11, 16'h00A8, 1'b0, 4'd7},  // R7 CS np + limit
    '{3'd0, 3'd2, 1'b0, 16'h00B0, 1'b0, 8'd11, 16'h00B0, 1'b1, 4'd8},  // R8 CS in task switch
    '{3'd2, 3'd2, 1'b0, 16'h00B8, 1'b0, 8'd11, 16'h00B8, 1'b1, 4'd8}   // R8 ES in task switch
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] tg, input logic [2:0] cx, input logic pr,
                       input logic [15:0] sel, input logic lim);
    @(negedge clk);
    req = 1'b1; target = tg; ctx = cx; present = pr; selector = sel; ss_limit_err = lim;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset fault_valid", 32'(fault_valid), 0);
    chk("R1 reset vector", 32'(vector), 0);
    chk("R1 reset err_code", 32'(err_code), 0);
    chk("R1 reset restart", 32'(restart_new_task), 0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      issue(TBL[i].tg, TBL[i].cx, TBL[i].pr, TBL[i].sel, TBL[i].lim);
      chk($sformatf("R%0d row %0d fault_valid", TBL[i].rq, i), 32'(fault_valid), 1);
      chk($sformatf("R%0d row %0d vector", TBL[i].rq, i), 32'(vector), 32'(TBL[i].evec));
      chk($sformatf("R%0d row %0d err_code", TBL[i].rq, i), 32'(err_code), 32'(TBL[i].eec));
      chk($sformatf("R8 row %0d restart", i), 32'(restart_new_task), 32'(TBL[i].ers));
      @(negedge clk);
      chk($sformatf("R9 row %0d pulse ends", i), 32'(fault_valid), 0);
    end

    issue(3'd4, 3'd1, 1'b0, 16'h0C0D, 1'b0);
    chk("R4 LLDT vector", 32'(vector), 11);
    issue(3'd1, 3'd0, 1'b1, 16'hFFFF, 1'b0);
    chk("R10 benign fault_valid", 32'(fault_valid), 0);
    chk("R10 benign keeps vector", 32'(vector), 11);
    chk("R10 benign keeps err_code", 32'(err_code), 32'h0C0D);
    issue(3'd6, 3'd0, 1'b0, 16'h7777, 1'b0);
    chk("R2 target 6 no fault", 32'(fault_valid), 0);
    chk("R10 target 6 keeps err_code", 32'(err_code), 32'h0C0D);

    @(negedge clk);
    req = 1'b1; target = 3'd0; ctx = 3'd2; present = 1'b0; selector = 16'h0D00; ss_limit_err = 1'b0;
    @(negedge clk);
    chk("R9 back-to-back first", 32'(fault_valid), 1);
    target = 3'd3; selector = 16'h0E00;
    @(negedge clk);
    req = 1'b0;
    chk("R9 back-to-back second", 32'(fault_valid), 1);
    chk("R3 back-to-back vector", 32'(vector), 12);
    chk("R8 back-to-back restart cleared", 32'(restart_new_task), 0);

    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset vector", 32'(vector), 0);
    chk("R1 mid-run reset err_code", 32'(err_code), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule